// File: doc/BRIEF.md
# Ethernet Station Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether the destination address of an incoming frame equals one of four station addresses programmed by software. Each 48-bit station address lives in a slot made of two 32-bit register words. A small write/read port reaches those words. Received bytes arrive one per `rx_valid` cycle, and `rx_sof` marks the first byte. After the sixth byte the block produces a one-cycle result. The result says whether a slot matched, which slot it was, and an accept code that encodes the slot. A separate flag reports the all-ones broadcast address.

Slots carry no explicit enable bit. Only the order of writes arms or disarms a slot. A write to the low word disarms the slot, and a write to the high word arms it. The usual update sequence is therefore low word, then high word, and the slot is never compared while half-written.

Top module: `eth_station_filter`

## Requirements
- R1: Word address 2s holds destination bytes 0..3 of slot s (byte 0 in bits 7:0). Word address 2s+1 holds bytes 4..5 in bits 15:0. On a high-word write only bits 15:0 are stored, and bits 31:16 of a high word always read as zero. `rd_data` reflects a write from the cycle after it.
- R2: Any write to a slot's low word makes that slot inactive, whatever the data.
- R3: Any write to a slot's high word makes that slot active.
- R4: After reset every slot is inactive and holds zero, so a frame with destination 00:00:00:00:00:00 reports no match.
- R5: An inactive slot never matches, even when its stored address equals the destination address. An active slot matches only when all six bytes are equal.
- R6: When several active slots match, the highest slot index wins.
- R7: On a match, `res_slot` is the winning index and `res_code` equals ACCEPT_BASE + index (default base 4, so slots 0..3 give codes 4..7). Without a match, `res_hit`, `res_slot` and `res_code` are zero.
- R8: `res_bcast` is 1 exactly when all six destination bytes are 0xFF.
- R9: `res_valid` pulses for exactly one cycle, in the cycle after the sixth destination byte is accepted. Cycles with `rx_valid` low between bytes stall the count. Bytes after the sixth, until the next `rx_sof`, produce no result. `res_hit` and `res_bcast` are zero whenever `res_valid` is low.
- R10: A register write in the same cycle as a frame's first byte affects only later frames. The running comparison uses the slot contents and active state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | Marks the first destination byte (with `rx_valid`) |
| rx_byte | input | 8 | Received byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | A station slot matched |
| res_slot | output | 2 | Index of the winning slot |
| res_code | output | 8 | Accept code, base plus slot index |
| res_bcast | output | 1 | Destination was all-ones broadcast |

## Verification
The bench builds the block with its default four slots and an accept base of 4. At that size an exhaustive sweep is practical: all 16 active-slot masks crossed with all 16 patterns of which slots hold the frame's address. Disabled slots still hold a stored address, reached by writing the high word before the low word. This covers every priority resolution and every way an inactive slot could wrongly match. Non-matching slots differ from the frame only in the last byte, so the full six-byte compare is exercised. Separate runs cover byte gaps, trailing bytes, broadcast detection, and writes that coincide with a frame's first byte.

// File: rtl/sa_filt_pkg.sv
package sa_filt_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int CODE_W    = 8;

  // Byte k of a stored address equals the received byte (k out of range: no match)
  function automatic logic byte_match(input logic [MAC_W-1:0] addr, input int k,
                                      input logic [7:0] b);
    if (k < 0 || k >= MAC_BYTES) return 1'b0;
    return addr[k*8 +: 8] == b;
  endfunction

  // Accept code reported for a winning slot
  function automatic logic [CODE_W-1:0] accept_code(input int base, input int idx);
    return CODE_W'(base + idx);
  endfunction
endpackage

// File: rtl/sa_slot_regs.sv
module sa_slot_regs
  import sa_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW        = $clog2(2 * NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_addr,
  input  logic [31:0]                     wr_data,
  input  logic [AW-1:0]                   rd_addr,
  output logic [31:0]                     rd_data,
  output logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr,
  output logic [NUM_SLOTS-1:0]            slot_active,
  output logic [NUM_SLOTS-1:0]            lo_wr,
  output logic [NUM_SLOTS-1:0]            hi_wr
);
  localparam int HI_W = MAC_W - 32;

  logic [NUM_SLOTS-1:0][MAC_W-1:0] addr_q;
  logic [NUM_SLOTS-1:0]            act_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    assign lo_wr[s] = wr_en && (wr_addr == AW'(2 * s));
    assign hi_wr[s] = wr_en && (wr_addr == AW'(2 * s + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      act_q  <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (lo_wr[s]) begin
          addr_q[s][31:0] <= wr_data;
          act_q[s]        <= 1'b0;
        end else if (hi_wr[s]) begin
          addr_q[s][MAC_W-1:32] <= wr_data[HI_W-1:0];
          act_q[s]              <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_addr == AW'(2 * s))     rd_data = addr_q[s][31:0];
      if (rd_addr == AW'(2 * s + 1)) rd_data = {{(32-HI_W){1'b0}}, addr_q[s][MAC_W-1:32]};
    end
  end

  assign slot_addr   = addr_q;
  assign slot_active = act_q;
endmodule

// File: rtl/sa_frame_tracker.sv
module sa_frame_tracker
  import sa_filt_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_valid,
  input  logic                            rx_sof,
  input  logic [7:0]                      rx_byte,
  input  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr,
  input  logic [NUM_SLOTS-1:0]            slot_active,
  output logic                            frame_done,
  output logic [NUM_SLOTS-1:0]            final_hit,
  output logic                            final_bcast
);
  localparam int CW = $clog2(MAC_BYTES + 1);

  logic [NUM_SLOTS-1:0][MAC_W-1:0] snap_q;
  logic [NUM_SLOTS-1:0]            run_hit_q, cur_hit;
  logic                            run_bc_q, cur_bc;
  logic [CW-1:0]                   cnt_q, pos;
  logic                            in_frame_q, first, take;

  assign first = rx_valid && rx_sof;
  assign take  = rx_valid && (rx_sof || in_frame_q);
  assign pos   = first ? '0 : cnt_q;

  // First byte compares against live slots; later bytes against the snapshot
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      cur_hit[s] = (first ? slot_active[s] : run_hit_q[s]) &&
                   byte_match(first ? slot_addr[s] : snap_q[s], int'(pos), rx_byte);
    end
    cur_bc = (first ? 1'b1 : run_bc_q) && (rx_byte == 8'hFF);
  end

  assign frame_done  = take && (pos == CW'(MAC_BYTES - 1));
  assign final_hit   = cur_hit;
  assign final_bcast = cur_bc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      run_hit_q  <= '0;
      run_bc_q   <= 1'b0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (take) begin
      if (first) snap_q <= slot_addr;
      run_hit_q  <= cur_hit;
      run_bc_q   <= cur_bc;
      cnt_q      <= pos + CW'(1);
      in_frame_q <= !frame_done;
    end
  end
endmodule

// File: rtl/sa_prio_pick.sv
module sa_prio_pick #(
  parameter int NUM_SLOTS = 4,
  parameter int SW        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] hit_vec,
  output logic                 any_hit,
  output logic [SW-1:0]        win_idx
);
  // Ascending scan: the last set bit (highest index) wins
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (hit_vec[s]) begin
        any_hit = 1'b1;
        win_idx = SW'(s);
      end
    end
  end
endmodule

// File: rtl/eth_station_filter.sv
module eth_station_filter
  import sa_filt_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ACCEPT_BASE = 4,
  parameter int AW          = $clog2(2 * NUM_SLOTS),
  parameter int SW          = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_byte,
  output logic              res_valid,
  output logic              res_hit,
  output logic [SW-1:0]     res_slot,
  output logic [CODE_W-1:0] res_code,
  output logic              res_bcast
);
  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0]            slot_active, lo_wr, hi_wr, final_hit;
  logic                            frame_done, final_bcast, any_hit;
  logic [SW-1:0]                   win_idx;

  sa_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slot_addr(slot_addr),
    .slot_active(slot_active), .lo_wr(lo_wr), .hi_wr(hi_wr)
  );

  sa_frame_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_track (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .slot_addr(slot_addr), .slot_active(slot_active), .frame_done(frame_done),
    .final_hit(final_hit), .final_bcast(final_bcast)
  );

  sa_prio_pick #(.NUM_SLOTS(NUM_SLOTS), .SW(SW)) u_pick (
    .hit_vec(final_hit), .any_hit(any_hit), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_slot  <= '0;
      res_code  <= '0;
      res_bcast <= 1'b0;
    end else begin
      res_valid <= frame_done;
      res_hit   <= frame_done && any_hit;
      res_slot  <= (frame_done && any_hit) ? win_idx : '0;
      res_code  <= (frame_done && any_hit) ? accept_code(ACCEPT_BASE, int'(win_idx)) : '0;
      res_bcast <= frame_done && final_bcast;
    end
  end
endmodule

// File: rtl/sa_filt_checker.sv
module sa_filt_checker
  import sa_filt_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ACCEPT_BASE = 4,
  parameter int AW          = $clog2(2 * NUM_SLOTS),
  parameter int SW          = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic [AW-1:0]        rd_addr,
  input logic [31:0]          rd_data,
  input logic [NUM_SLOTS-1:0] slot_active,
  input logic                 frame_done,
  input logic                 res_valid,
  input logic                 res_hit,
  input logic [SW-1:0]        res_slot,
  input logic [CODE_W-1:0]    res_code,
  input logic                 res_bcast
);
  AST_HIGH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) < 2 * NUM_SLOTS && rd_addr[0]) |-> rd_data[31:16] == 16'h0); // R1
  AST_LOW_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[0] && int'(wr_addr) < 2 * NUM_SLOTS)
      |=> !slot_active[int'($past(wr_addr)) / 2]); // R2
  AST_HIGH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[0] && int'(wr_addr) < 2 * NUM_SLOTS)
      |=> slot_active[int'($past(wr_addr)) / 2]); // R3
  AST_CODE_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> res_code == accept_code(ACCEPT_BASE, int'(res_slot))); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_code == '0 && res_slot == '0)); // R7
  AST_RESULT_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> res_valid); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_bcast)); // R9
endmodule

bind eth_station_filter sa_filt_checker #(
  .NUM_SLOTS(NUM_SLOTS), .ACCEPT_BASE(ACCEPT_BASE), .AW(AW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .slot_active(slot_active), .frame_done(frame_done),
  .res_valid(res_valid), .res_hit(res_hit), .res_slot(res_slot), .res_code(res_code),
  .res_bcast(res_bcast)
);

// File: tb/sim_eth_station_filter.sv
`timescale 1ns/1ps
module sim_eth_station_filter;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        res_valid, res_hit, res_bcast;
  logic [1:0]  res_slot;
  logic [7:0]  res_code;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // Captured by send_frame
  logic       g_v, g_hit, g_bc, g_pre;
  logic [1:0] g_slot;
  logic [7:0] g_code;
  int         g_post;

  always #4 clk = ~clk;

  eth_station_filter #(.NUM_SLOTS(4), .ACCEPT_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .res_valid(res_valid), .res_hit(res_hit), .res_slot(res_slot),
    .res_code(res_code), .res_bcast(res_bcast)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input int s, input logic [47:0] a, input bit arm);
    if (arm) begin
      wr(3'(2*s), a[31:0]);
      wr(3'(2*s+1), {16'hDEAD, a[47:32]});
    end else begin
      wr(3'(2*s+1), {16'hBEEF, a[47:32]});
      wr(3'(2*s), a[31:0]);
    end
  endtask

  task automatic send_frame(input logic [47:0] da, input int gap, input int extra,
                            input bit cw, input logic [2:0] ca, input logic [31:0] cd);
    g_pre = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (res_valid) g_pre = 1'b1;
      rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = da[8*k +: 8];
      wr_en = (k == 0) && cw; wr_addr = ca; wr_data = cd;
      if (k < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (res_valid) g_pre = 1'b1;
          rx_valid = 1'b0; rx_sof = 1'b0; wr_en = 1'b0;
        end
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    g_v = res_valid; g_hit = res_hit; g_slot = res_slot; g_code = res_code; g_bc = res_bcast;
    g_post = 0;
    for (int e = 0; e < extra + 3; e++) begin
      rx_sof = 1'b0;
      rx_valid = (e < extra);
      rx_byte = 8'(8'h30 + e);
      @(negedge clk);
      if (res_valid) g_post++;
    end
    rx_valid = 1'b0;
  endtask

  function automatic int top_slot(input logic [3:0] m);
    int r = -1;
    for (int s = 0; s < 4; s++) if (m[s]) r = s;
    return r;
  endfunction

  localparam logic [47:0] A = 48'h5A13_C477_02E9;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    chk(res_valid == 1'b0, "R4 reset valid", res_valid, 0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk(rd_data == 32'h0, "R4 reset word", rd_data, 0);
    end
    send_frame(48'h0, 0, 0, 0, 3'd0, 32'h0);
    chk(g_v && !g_hit && g_code == 0, "R4 no match after reset", {g_v, g_hit, g_code}, 10'h200);

    // R1: register layout and readback
    for (int s = 0; s < 4; s++) begin
      wr(3'(2*s), 32'h1111_0000 * (s + 1) + 32'h0101 * s);
      wr(3'(2*s+1), 32'hFFFF_0000 | (32'h0A0B + 32'(s)));
    end
    for (int s = 0; s < 4; s++) begin
      rd_addr = 3'(2*s); #1;
      chk(rd_data == 32'h1111_0000 * (s + 1) + 32'h0101 * s, "R1 low word", rd_data,
          32'h1111_0000 * (s + 1) + 32'h0101 * s);
      rd_addr = 3'(2*s+1); #1;
      chk(rd_data == 32'h0A0B + 32'(s), "R1 high word masked", rd_data, 32'h0A0B + 32'(s));
    end
    // R1: byte 0 of the low word is the first received byte
    prog(2, A, 1);
    rd_addr = 3'd4; #1;
    chk(rd_data[7:0] == A[7:0], "R1 byte0 position", rd_data[7:0], A[7:0]);
    send_frame(A, 0, 0, 0, 3'd0, 32'h0);
    chk(g_hit && g_slot == 2, "R1 layout match", {g_hit, g_slot}, 3'b110);

    // R2 R3 R5 R6 R7: exhaustive arm mask x equality mask
    for (int en = 0; en < 16; en++) begin
      for (int eq = 0; eq < 16; eq++) begin
        logic [3:0] m;
        int ts;
        for (int s = 0; s < 4; s++)
          prog(s, eq[s] ? A : (A ^ (48'd1 << (40 + s))), en[s]);
        send_frame(A, 0, 0, 0, 3'd0, 32'h0);
        m  = 4'(en & eq);
        ts = top_slot(m);
        if (ts < 0)
          chk(g_v && !g_hit && g_slot == 0 && g_code == 0, "R5 R2 R7 miss",
              {g_v, g_hit, g_slot, g_code}, 12'h800);
        else
          chk(g_v && g_hit && g_slot == 2'(ts) && g_code == 8'(BASE + ts), "R6 R3 R7 hit",
              {g_v, g_hit, g_slot, g_code}, {1'b1, 1'b1, 2'(ts), 8'(BASE + ts)});
        chk(!g_bc, "R8 not broadcast", g_bc, 0);
      end
    end

    // R9: gaps, trailing bytes, single pulse
    prog(0, A, 1); prog(1, A, 0); prog(2, A, 0); prog(3, A, 0);
    send_frame(A, 2, 0, 0, 3'd0, 32'h0);
    chk(g_v && g_hit && g_slot == 0 && !g_pre && g_post == 0, "R9 gaps timing",
        {g_v, g_hit, g_pre, 32'(g_post)}, 35'h6_0000_0000);
    send_frame(A, 0, 5, 0, 3'd0, 32'h0);
    chk(g_v && g_hit && !g_pre && g_post == 0, "R9 trailing bytes ignored",
        {g_v, g_hit, g_pre, 32'(g_post)}, 35'h6_0000_0000);

    // R8: broadcast detection
    send_frame(48'hFFFF_FFFF_FFFF, 1, 0, 0, 3'd0, 32'h0);
    chk(g_v && g_bc && !g_hit, "R8 broadcast", {g_v, g_bc, g_hit}, 3'b110);
    send_frame(48'hFEFF_FFFF_FFFF, 0, 0, 0, 3'd0, 32'h0);
    chk(g_v && !g_bc, "R8 last byte not FF", {g_v, g_bc}, 2'b10);
    send_frame(48'hFFFF_FFFF_FF7F, 0, 0, 0, 3'd0, 32'h0);
    chk(g_v && !g_bc, "R8 first byte not FF", {g_v, g_bc}, 2'b10);

    // R10: write coinciding with first byte affects only later frames
    send_frame(A, 0, 0, 1, 3'd0, A[31:0]);
    chk(g_v && g_hit && g_slot == 0, "R10 disarm at sof keeps frame", {g_v, g_hit}, 2'b11);
    send_frame(A, 0, 0, 0, 3'd0, 32'h0);
    chk(g_v && !g_hit, "R10 R2 next frame misses", {g_v, g_hit}, 2'b10);
    send_frame(A, 0, 0, 1, 3'd1, {16'h0, A[47:32]});
    chk(g_v && !g_hit, "R10 arm at sof ignored", {g_v, g_hit}, 2'b10);
    send_frame(A, 0, 0, 0, 3'd0, 32'h0);
    chk(g_v && g_hit && g_slot == 0, "R10 R3 next frame hits", {g_v, g_hit, g_slot}, 4'b1100);
    // R10: address change at sof does not alter the running compare
    prog(3, A, 1);
    send_frame(A, 1, 0, 1, 3'd6, 32'h0000_0000);
    chk(g_v && g_hit && g_slot == 3, "R10 snapshot address", {g_hit, g_slot}, 3'b111);
    send_frame(A, 0, 0, 0, 3'd0, 32'h0);
    chk(g_v && g_hit && g_slot == 0, "R10 R6 new address used", {g_hit, g_slot}, 3'b100);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule